// File: doc/BRIEF.md
# Shared External Bus Ownership Arbiter

This block decides, cycle by cycle, whether the on-chip controller or a single external master owns a shared external bus. Three active-low handshake lines carry the negotiation. The external master raises a request on the request line and is answered on the grant line. Whichever party is running a transfer signals it on the busy line. Four internal status inputs steer the decision:
- a pending internal request;
- a flag that gives the external master precedence;
- an indication that an on-chip transfer is in progress or starts on the next cycle;
- a flag that marks a grant given only recently.

Ownership never changes in one step. When ownership moves towards the controller, the arbiter passes through a waiting state until the external master releases busy and no recent grant is outstanding. When ownership moves towards the external master, it waits until the on-chip transfer has finished. The request and busy inputs come from off chip, so each passes through a two-flop synchronizer before it reaches the decision logic. The grant line is a plain output. The busy line is modelled as an output value plus an output enable, which the pad logic outside this block uses.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the arbiter enters the controller-idle state. After that edge, `bg_n_o` is 1 and `bb_oe_o` is 0.
- R2: `br_n_i` and `bb_n_i` each pass through two flip-flops before the decision logic. A request on `br_n_i` (0 = asserted) that is applied before clock edge k first changes the state at edge k+2. In the test setup it therefore shows on `bg_n_o` after edge k+2.
- R3: From controller-idle, the next state is controller-busy when `mcu_xfer_i` is 1. It is also controller-busy when `int_req_i` is 1 and either `ext_prio_i` is 0 or the synchronized request is negated.
- R4: From controller-idle, with `mcu_xfer_i` at 0, the next state is external-owner when the synchronized request is asserted and either `int_req_i` is 0 or `ext_prio_i` is 1. In every other case the arbiter stays in controller-idle.
- R5: In external-owner, the arbiter moves to controller-wait when `int_req_i` is 1 and either `ext_prio_i` is 0 or the synchronized request is negated. Otherwise it stays in external-owner.
- R6: In controller-wait, the arbiter stays while the synchronized busy is asserted or `recent_grant_i` is 1. Otherwise it moves to controller-busy.
- R7: In controller-busy, the arbiter moves to external-wait when the synchronized request is asserted, `ext_prio_i` is 1 and `mcu_xfer_i` is 1. It stays in controller-busy in any of these cases:
  - the synchronized request is negated and `mcu_xfer_i` is 1;
  - the synchronized request is negated and `int_req_i` is 1;
  - `int_req_i` is 1 and `ext_prio_i` is 0.

  In all other cases it returns to controller-idle.
- R8: In external-wait, the arbiter moves to external-owner once `mcu_xfer_i` is 0. Otherwise it stays in external-wait.
- R9: `bg_n_o` is 0 in external-owner and in external-wait. It is 1 in the other three states.
- R10: `bb_oe_o` is 1 only in controller-busy and in external-wait. While it is 1, `bb_n_o` equals the inverse of `mcu_xfer_i`. While it is 0, `bb_n_o` is 1.
- R11: `bg_n_o` at 0 together with `bb_oe_o` at 1 occurs only in external-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_n_i | input | 1 | External bus request, active low, asynchronous |
| bb_n_i | input | 1 | Bus busy as seen on the pad, active low, asynchronous |
| int_req_i | input | 1 | An on-chip transfer request is pending |
| ext_prio_i | input | 1 | The external master takes precedence |
| mcu_xfer_i | input | 1 | An on-chip transfer is in progress or starts next cycle |
| recent_grant_i | input | 1 | A grant was given recently; hold off the takeover |
| bg_n_o | output | 1 | Bus grant to the external master, active low |
| bb_oe_o | output | 1 | Output enable for the busy driver |
| bb_n_o | output | 1 | Value driven on busy while enabled |

## Verification
A directed sequence walks every transition at least once:
- takeover by the external master from idle;
- a takeover from idle that fails because precedence lies with the controller;
- the wait state held first by busy and then by the recent-grant flag;
- the handoff from busy through external-wait.

The held state and the departing state produce the same outputs at first, so sequences that alternate a condition on and off show whether each guard term is present. A single-cycle request pulse on the request line shows the two-cycle synchronizer latency. It separates a missing stage from a correct one. Long random runs with biased input probabilities then reach the rarer combinations. These include a request with precedence while a transfer is running, and a recent grant that coincides with busy being released.

// File: rtl/arb_pkg.sv
// Package: shared state type and default sizes for the external bus arbiter.
// Assumes every module of the arbiter imports it before use.
package arb_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned STATE_W         = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_MCU_IDLE = 3'd0,
        ST_EXT_OWN  = 3'd1,
        ST_MCU_WAIT = 3'd2,
        ST_MCU_BUSY = 3'd3,
        ST_EXT_WAIT = 3'd4
    } arb_state_e;

    // Status inputs bundled for the next-state logic.
    typedef struct packed {
        logic br_act;
        logic bb_act;
        logic irp;
        logic ehp;
        logic etp;
        logic rbg;
    } arb_cond_t;

endpackage

// File: rtl/arb_sync.sv
// Module: multi-bit synchronizer chain for asynchronous inputs.
// Each bit passes through STAGES flops. Reset loads RESET_VAL, which is the
// negated level for active-low handshake lines. Assumes STAGES >= 1.
module arb_sync #(
    parameter int unsigned WIDTH     = 2,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: shift the value one flop further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/arb_next_state.sv
// Module: combinational next-state logic of the ownership arbiter.
// Assumes the request and busy conditions arrive already synchronized and
// active high. An unknown state encoding falls back to controller-idle.
module arb_next_state
    import arb_pkg::*;
(
    input  arb_state_e cur_i,
    input  arb_cond_t  c_i,
    output arb_state_e nxt_o
);

    logic mcu_may_take;   // internal request that may proceed
    logic ext_may_take;   // external request that may proceed
    logic busy_keep;      // a reason to keep the controller as owner
    logic ext_preempt;    // external master takes over a running transfer

    // Purpose: derive the shared guard terms from the status inputs.
    always_comb begin
        mcu_may_take = c_i.irp && (!c_i.ehp || !c_i.br_act);
        ext_may_take = c_i.br_act && (!c_i.irp || c_i.ehp);
        busy_keep    = (!c_i.br_act && (c_i.etp || c_i.irp)) ||
                       (c_i.irp && !c_i.ehp);
        ext_preempt  = c_i.br_act && c_i.ehp && c_i.etp;
    end

    // Purpose: choose the next state from the current state and guards.
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            ST_MCU_IDLE: begin
                if (mcu_may_take || c_i.etp) nxt_o = ST_MCU_BUSY;
                else if (ext_may_take)       nxt_o = ST_EXT_OWN;
                else                         nxt_o = ST_MCU_IDLE;
            end
            ST_EXT_OWN: begin
                if (mcu_may_take) nxt_o = ST_MCU_WAIT;
                else              nxt_o = ST_EXT_OWN;
            end
            ST_MCU_WAIT: begin
                if (c_i.bb_act || c_i.rbg) nxt_o = ST_MCU_WAIT;
                else                       nxt_o = ST_MCU_BUSY;
            end
            ST_MCU_BUSY: begin
                if (ext_preempt)    nxt_o = ST_EXT_WAIT;
                else if (busy_keep) nxt_o = ST_MCU_BUSY;
                else                nxt_o = ST_MCU_IDLE;
            end
            ST_EXT_WAIT: begin
                if (!c_i.etp) nxt_o = ST_EXT_OWN;
                else          nxt_o = ST_EXT_WAIT;
            end
            default: nxt_o = ST_MCU_IDLE;
        endcase
    end

endmodule

// File: rtl/arb_out_decode.sv
// Module: output decode of the ownership arbiter.
// Grant is a pure function of the state. The busy value follows the on-chip
// transfer indication while the driver is enabled; otherwise it is 1.
module arb_out_decode
    import arb_pkg::*;
(
    input  arb_state_e st_i,
    input  logic       etp_i,
    output logic       bg_n_o,
    output logic       bb_oe_o,
    output logic       bb_n_o
);

    // Purpose: map the state to grant and busy driver controls.
    always_comb begin
        bg_n_o  = 1'b1;
        bb_oe_o = 1'b0;
        unique case (st_i)
            ST_EXT_OWN:  bg_n_o = 1'b0;
            ST_EXT_WAIT: begin
                bg_n_o  = 1'b0;
                bb_oe_o = 1'b1;
            end
            ST_MCU_BUSY: bb_oe_o = 1'b1;
            default: begin
                bg_n_o  = 1'b1;
                bb_oe_o = 1'b0;
            end
        endcase
    end

    // Purpose: drive busy low for a running transfer, high otherwise.
    always_comb begin
        bb_n_o = bb_oe_o ? !etp_i : 1'b1;
    end

endmodule

// File: rtl/ext_bus_arbiter.sv
// Module: top of the shared external bus ownership arbiter.
// Synchronizes the request and busy pad inputs, holds the state register and
// decodes grant and busy driver controls. Assumes the status inputs are
// already synchronous to clk.
module ext_bus_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic br_n_i,
    input  logic bb_n_i,
    input  logic int_req_i,
    input  logic ext_prio_i,
    input  logic mcu_xfer_i,
    input  logic recent_grant_i,
    output logic bg_n_o,
    output logic bb_oe_o,
    output logic bb_n_o
);

    localparam int unsigned PAD_W = 2;

    logic [PAD_W-1:0] pad_raw;
    logic [PAD_W-1:0] pad_sync;
    arb_cond_t        cond;
    arb_state_e       state_q;
    arb_state_e       state_d;

    assign pad_raw = {br_n_i, bb_n_i};

    arb_sync #(
        .WIDTH    (PAD_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({PAD_W{1'b1}})
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pad_raw),
        .q_o  (pad_sync)
    );

    // Purpose: gather synchronized pad levels and status flags as active high.
    always_comb begin
        cond.br_act = !pad_sync[1];
        cond.bb_act = !pad_sync[0];
        cond.irp    = int_req_i;
        cond.ehp    = ext_prio_i;
        cond.etp    = mcu_xfer_i;
        cond.rbg    = recent_grant_i;
    end

    arb_next_state i_next (
        .cur_i(state_q),
        .c_i  (cond),
        .nxt_o(state_d)
    );

    // Purpose: state register, reset into controller-idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MCU_IDLE;
        else        state_q <= state_d;
    end

    arb_out_decode i_dec (
        .st_i   (state_q),
        .etp_i  (mcu_xfer_i),
        .bg_n_o (bg_n_o),
        .bb_oe_o(bb_oe_o),
        .bb_n_o (bb_n_o)
    );

    // R11: grant and busy driver together only in external-wait
    p_grant_with_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bg_n_o && bb_oe_o) |-> (state_q == ST_EXT_WAIT));

    // R6: controller-wait holds while the busy line is still asserted
    p_wait_holds_on_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MCU_WAIT && cond.bb_act) |=> (state_q == ST_MCU_WAIT));

    // R8: external-wait releases to external-owner once the transfer ends
    p_ext_wait_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT_WAIT && !mcu_xfer_i) |=> (state_q == ST_EXT_OWN));

    // R10: busy driver disabled outside controller-busy and external-wait
    p_no_drive_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_MCU_IDLE, ST_EXT_OWN, ST_MCU_WAIT}) |-> (!bb_oe_o && bb_n_o));

    // R5: the grant is never taken back without passing controller-wait
    p_ext_leaves_via_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT_OWN) |=> (state_q inside {ST_EXT_OWN, ST_MCU_WAIT}));

    // R3: a running on-chip transfer takes the bus from controller-idle
    p_idle_to_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MCU_IDLE && mcu_xfer_i) |=> (state_q == ST_MCU_BUSY));

endmodule

// File: tb/test_ext_bus_arbiter.sv
module test_ext_bus_arbiter;

    localparam int MAX_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_n = 1'b1, bb_n = 1'b1;
    logic irp = 1'b0, ehp = 1'b0, etp = 1'b0, rbg = 1'b0;
    logic bg_n, bb_oe, bb_drv;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state: 0 idle, 1 ext owner, 2 mcu wait, 3 mcu busy, 4 ext wait
    int m_st = 0;
    int m_prev = 0;
    bit br_q[$];
    bit bb_q[$];

    always #4 clk = ~clk;

    ext_bus_arbiter i_ext_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .br_n_i(br_n), .bb_n_i(bb_n),
        .int_req_i(irp), .ext_prio_i(ehp), .mcu_xfer_i(etp),
        .recent_grant_i(rbg), .bg_n_o(bg_n), .bb_oe_o(bb_oe), .bb_n_o(bb_drv)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b cycle=%0d", req, what, act, exp, cycles);
        end
    endtask

    function automatic string trans_tag(input int from);
        case (from)
            0: return (m_st == 3) ? "R3" : "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Compare all outputs with the reference model (called away from the edge)
    task automatic compare_all();
        logic e_bg, e_oe, e_bb;
        e_bg = !(m_st == 1 || m_st == 4);
        e_oe = (m_st == 3 || m_st == 4);
        e_bb = e_oe ? !etp : 1'b1;
        check(trans_tag(m_prev), bg_n, e_bg, "grant after transition");
        check("R9", bg_n, e_bg, "bg_n");
        check("R10", bb_oe, e_oe, "bb_oe");
        check("R10", bb_drv, e_bb, "bb_n");
        if (!bg_n && bb_oe) check("R11", 1'b1, (m_st == 4), "grant with drive");
    endtask

    // Advance the model by one rising edge using the inputs now applied
    task automatic model_edge();
        bit br_a, bb_a;
        int nx;
        m_prev = m_st;
        if (!rst_n) begin
            m_st = 0;
            br_q = '{1'b1, 1'b1};
            bb_q = '{1'b1, 1'b1};
            return;
        end
        br_a = !br_q[0];
        bb_a = !bb_q[0];
        nx = m_st;
        if (m_st == 0) begin
            if (etp) nx = 3;
            else if (irp && !ehp) nx = 3;
            else if (irp && !br_a) nx = 3;
            else if (br_a) nx = 1;
        end else if (m_st == 1) begin
            if (irp && (!br_a || !ehp)) nx = 2;
        end else if (m_st == 2) begin
            if (!bb_a && !rbg) nx = 3;
        end else if (m_st == 3) begin
            if (br_a && ehp && etp) nx = 4;
            else if (!br_a && etp) nx = 3;
            else if (!br_a && irp) nx = 3;
            else if (irp && !ehp) nx = 3;
            else nx = 0;
        end else begin
            if (!etp) nx = 1;
        end
        m_st = nx;
        void'(br_q.pop_front());
        void'(bb_q.pop_front());
        br_q.push_back(br_n);
        bb_q.push_back(bb_n);
    endtask

    // One cycle: model the coming edge, wait for it, compare at the falling edge
    task automatic step();
        model_edge();
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic drive(input logic b, input logic bb, input logic i, input logic e,
                         input logic t, input logic g);
        br_n = b; bb_n = bb; irp = i; ehp = e; etp = t; rbg = g;
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        br_q = '{1'b1, 1'b1};
        bb_q = '{1'b1, 1'b1};
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) step();
        // R1: reset state
        check("R1", bg_n, 1'b1, "bg_n after reset");
        check("R1", bb_oe, 1'b0, "bb_oe after reset");
        rst_n = 1'b1;
        drive(1, 1, 0, 0, 0, 0);
        repeat (2) step();

        // R2: request latency through the synchronizer (state changes at third edge)
        drive(0, 1, 0, 0, 0, 0);
        step();
        step();
        check("R2", bg_n, 1'b1, "grant two edges after request");
        step();
        check("R2", bg_n, 1'b0, "grant three edges after request");
        check("R4", bg_n, 1'b0, "idle to external owner");

        // R5: stays external owner with priority and request, then leaves
        drive(0, 0, 1, 1, 0, 0);
        repeat (3) step();
        check("R5", bg_n, 1'b0, "external owner held by priority");
        drive(0, 0, 1, 0, 0, 0);
        step();
        check("R5", bg_n, 1'b1, "external owner to controller wait");

        // R6: wait held by busy, then by recent grant, then released
        repeat (3) step();
        check("R6", bb_oe, 1'b0, "wait held while busy asserted");
        drive(0, 1, 1, 0, 0, 1);
        repeat (4) step();
        check("R6", bb_oe, 1'b0, "wait held by recent grant");
        drive(0, 1, 1, 0, 1, 0);
        step();
        check("R6", bb_oe, 1'b1, "wait to controller busy");

        // R7 / R8: preemption through external wait
        drive(0, 1, 1, 1, 1, 0);
        step();
        check("R7", bg_n, 1'b0, "busy to external wait");
        check("R11", bb_oe, 1'b1, "drive kept in external wait");
        check("R10", bb_drv, 1'b0, "busy driven low during transfer");
        step();
        drive(0, 1, 0, 1, 0, 0);
        step();
        check("R8", bb_oe, 1'b0, "external wait to owner");

        // R7: return to idle from busy
        drive(1, 1, 1, 0, 0, 0);
        repeat (6) step();
        drive(1, 1, 0, 0, 0, 0);
        repeat (3) step();
        check("R7", bb_oe, 1'b0, "busy back to idle");

        // R4: no internal request and no external request keeps idle
        repeat (3) step();
        check("R4", bg_n, 1'b1, "idle stays idle");

        // Random phase with biased probabilities
        for (int n = 0; n < 4000; n++) begin
            drive(($urandom_range(0, 99) < 55), ($urandom_range(0, 99) < 60),
                  ($urandom_range(0, 99) < 45), ($urandom_range(0, 99) < 50),
                  ($urandom_range(0, 99) < 40), ($urandom_range(0, 99) < 25));
            if (n % 997 == 500) rst_n = 1'b0;
            else rst_n = 1'b1;
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule